// File: doc/BRIEF.md
# SPI Master Transfer Engine

This block runs one SPI transaction at a time toward a single slave. A transaction is requested with a one-cycle start strobe. At that moment the block takes a word-length code, a serial clock divider, a chip-select lead delay and a transmit word. It pulls the chip select low and waits out the lead delay. It then clocks the word out on MOSI, most significant bit first, while it collects the same number of bits from MISO. At the end it releases the chip select and pulses `done` with the received word.

The serial clock idles low. MOSI changes on falling edges, and MISO is captured on rising edges. The divider counts system clocks, so the serial clock period is the divider value in system cycles. For odd values the high phase is the shorter one. The configuration is latched when the start is accepted, so the inputs may change during a transfer. An illegal configuration is refused with a one-cycle error flag and no bus activity.

Top module: `spi_xfer_master`

## Requirements
- R1: The word length is `len_code + 8` bits, so code 0 gives 8 bits and code 8 gives 16 bits. Exactly that many rising serial clock edges occur, and MOSI presents the low `len_code + 8` bits of `tx_word`, most significant first.
- R2: A start with `len_code` in 9..15 is refused. `cfg_err` is high in the cycle after the strobe and low again one cycle later, and `cs_n` stays high and `busy` stays low.
- R3: A start with `clk_div` equal to 0 is refused in the same way as in R2.
- R4: For `clk_div` N of 2 or more, the serial clock stays high for floor(N/2) system cycles and low for N - floor(N/2). For N = 1 both phases last one cycle.
- R5: When `cs_delay` D is nonzero, the first rising serial clock edge comes D system cycles after `cs_n` falls.
- R6: When `cs_delay` is 0, that lead equals the low-phase length of R4.
- R7: The serial clock is low whenever `cs_n` is high. MOSI holds the first bit from the cycle in which `cs_n` falls, and MOSI never changes while the serial clock is high.
- R8: MISO is sampled at each rising edge. `rx_word` holds the received bits right-justified, and its unused upper bits are zero.
- R9: `cs_n` rises, and the serial clock falls, floor(N/2) cycles after the last rising edge (one cycle for N = 1). `done` is high for exactly that one cycle, with `rx_word` valid, and `rx_word` holds its value afterwards.
- R10: `busy` and a low `cs_n` appear in the cycle after an accepted start, and `busy` drops with `done`. A start while `busy` is high has no effect.
- R11: After reset, `cs_n` is 1, and `sclk`, `mosi`, `busy`, `done`, `cfg_err` and `rx_word` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle transfer request |
| len_code | input | 4 | Word length code (bits = code + 8), codes 9..15 illegal |
| clk_div | input | 8 | Serial clock period in system cycles, 0 illegal |
| cs_delay | input | 8 | Cycles from chip select low to first clock edge, 0 = half period |
| tx_word | input | 16 | Word to send, right-justified |
| miso | input | 1 | Serial data from slave |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to slave |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| cfg_err | output | 1 | One-cycle pulse on a refused start |
| rx_word | output | 16 | Received word, right-justified |

## Verification
A wrong phase timer value shows up within one serial period as a high or low width that is off by a cycle, or as a wrong lead before the first edge. A bit counter that is off changes the number of rising edges, and it moves both `done` and the release of `cs_n` by whole periods. A shift register that is misaligned gives a wrong MOSI pattern at the slave and a wrong `rx_word` at `done`. The checks on illegal configurations watch the outputs in the cycle right after the strobe, so a leaked transfer shows up at once as a falling `cs_n`.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_HIGH = 2'd2,
    ST_LOW  = 2'd3
  } xfer_state_t;
endpackage

// File: rtl/spi_xfer_cfg.sv
// Validates a configuration and turns it into phase lengths.
module spi_xfer_cfg #(
  parameter int CODE_W   = 4,
  parameter int DIV_W    = 8,
  parameter int DLY_W    = 8,
  parameter int T_W      = 8,
  parameter int MIN_BITS = 8,
  parameter int MAX_BITS = 16,
  parameter int CNT_W    = 5
) (
  input  logic [CODE_W-1:0] len_code,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic [DLY_W-1:0]  cs_delay,
  output logic              cfg_ok,
  output logic [CNT_W-1:0]  nbits,
  output logic [DIV_W-1:0]  hi_len,
  output logic [DIV_W-1:0]  lo_len,
  output logic [T_W-1:0]    lead_len
);
  localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(MAX_BITS - MIN_BITS);

  logic [DIV_W-1:0] half;

  always_comb begin
    half     = clk_div >> 1;
    cfg_ok   = (len_code <= MAX_CODE) && (clk_div != '0);
    nbits    = CNT_W'(len_code) + CNT_W'(MIN_BITS);
    // a divider of one cannot toggle a registered pin each cycle: one cycle per phase
    hi_len   = (half == '0) ? DIV_W'(1) : half;
    lo_len   = clk_div - half;
    lead_len = (cs_delay != '0) ? T_W'(cs_delay) : T_W'(lo_len);
  end
endmodule

// File: rtl/spi_xfer_timer.sv
// Down counter for one phase; expire is high in the phase's final cycle.
module spi_xfer_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expire
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val - W'(1);
    else if (cnt != '0)   cnt <= cnt - W'(1);
  end

  assign expire = (cnt == '0);
endmodule

// File: rtl/spi_xfer_shifter.sv
// Transmit and receive shift registers.
module spi_xfer_shifter #(
  parameter int MAX_BITS = 16,
  parameter int CNT_W    = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                clear,
  input  logic [CNT_W-1:0]    nbits,
  input  logic [MAX_BITS-1:0] tx_word,
  input  logic                shift,
  input  logic                sample,
  input  logic                miso,
  output logic                mosi,
  output logic [MAX_BITS-1:0] rx_data
);
  logic [MAX_BITS-1:0] tx_sr;
  logic [CNT_W-1:0]    shamt;

  assign shamt = CNT_W'(MAX_BITS) - nbits;

  always_ff @(posedge clk) begin
    if (rst || clear)  tx_sr <= '0;
    else if (load)     tx_sr <= tx_word << shamt;
    else if (shift)    tx_sr <= {tx_sr[MAX_BITS-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst || load)   rx_data <= '0;
    else if (sample)   rx_data <= {rx_data[MAX_BITS-2:0], miso};
  end

  assign mosi = tx_sr[MAX_BITS-1];
endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master
  import spi_xfer_pkg::*;
#(
  parameter int CODE_W   = 4,
  parameter int DIV_W    = 8,
  parameter int DLY_W    = 8,
  parameter int MIN_BITS = 8,
  parameter int MAX_BITS = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [CODE_W-1:0]   len_code,
  input  logic [DIV_W-1:0]    clk_div,
  input  logic [DLY_W-1:0]    cs_delay,
  input  logic [MAX_BITS-1:0] tx_word,
  input  logic                miso,
  output logic                cs_n,
  output logic                sclk,
  output logic                mosi,
  output logic                busy,
  output logic                done,
  output logic                cfg_err,
  output logic [MAX_BITS-1:0] rx_word
);
  localparam int T_W   = (DIV_W > DLY_W) ? DIV_W : DLY_W;
  localparam int CNT_W = $clog2(MAX_BITS + 1);

  xfer_state_t state;

  logic             cfg_ok;
  logic [CNT_W-1:0] nbits;
  logic [DIV_W-1:0] hi_len, lo_len, hi_q, lo_q;
  logic [T_W-1:0]   lead_len, tmr_val;
  logic [CNT_W-1:0] bits_left;
  logic             expire, tmr_load;
  logic             accept, reject, sample, shift, finish;
  logic [MAX_BITS-1:0] rx_data;

  spi_xfer_cfg #(
    .CODE_W(CODE_W), .DIV_W(DIV_W), .DLY_W(DLY_W), .T_W(T_W),
    .MIN_BITS(MIN_BITS), .MAX_BITS(MAX_BITS), .CNT_W(CNT_W)
  ) i_cfg (
    .len_code(len_code), .clk_div(clk_div), .cs_delay(cs_delay),
    .cfg_ok(cfg_ok), .nbits(nbits), .hi_len(hi_len), .lo_len(lo_len),
    .lead_len(lead_len)
  );

  spi_xfer_timer #(.W(T_W)) i_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expire(expire)
  );

  spi_xfer_shifter #(.MAX_BITS(MAX_BITS), .CNT_W(CNT_W)) i_shift (
    .clk(clk), .rst(rst), .load(accept), .clear(finish), .nbits(nbits),
    .tx_word(tx_word), .shift(shift), .sample(sample), .miso(miso),
    .mosi(mosi), .rx_data(rx_data)
  );

  always_comb begin
    accept   = start && (state == ST_IDLE) && cfg_ok;
    reject   = start && (state == ST_IDLE) && !cfg_ok;
    sample   = ((state == ST_LEAD) || (state == ST_LOW)) && expire;
    shift    = (state == ST_HIGH) && expire && (bits_left != '0);
    finish   = (state == ST_HIGH) && expire && (bits_left == '0);
    tmr_load = accept || sample || shift;
    if (accept)      tmr_val = lead_len;
    else if (sample) tmr_val = T_W'(hi_q);
    else             tmr_val = T_W'(lo_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cs_n      <= 1'b1;
      sclk      <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      cfg_err   <= 1'b0;
      rx_word   <= '0;
      bits_left <= '0;
      hi_q      <= '0;
      lo_q      <= '0;
    end else begin
      done    <= finish;
      cfg_err <= reject;
      if (accept) begin
        state     <= ST_LEAD;
        cs_n      <= 1'b0;
        busy      <= 1'b1;
        bits_left <= nbits;
        hi_q      <= hi_len;
        lo_q      <= lo_len;
      end
      if (sample) begin
        state     <= ST_HIGH;
        sclk      <= 1'b1;
        bits_left <= bits_left - CNT_W'(1);
      end
      if (shift) begin
        state <= ST_LOW;
        sclk  <= 1'b0;
      end
      if (finish) begin
        state   <= ST_IDLE;
        sclk    <= 1'b0;
        cs_n    <= 1'b1;
        busy    <= 1'b0;
        rx_word <= rx_data;
      end
    end
  end
endmodule

// File: rtl/spi_xfer_master_chk.sv
module spi_xfer_master_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic cs_n,
  input logic sclk,
  input logic mosi,
  input logic busy,
  input logic done,
  input logic cfg_err
);
  assert_sclk_idle_R7: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  assert_mosi_hold_R7: assert property (@(posedge clk) disable iff (rst)
    sclk |-> $stable(mosi));

  assert_err_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> (cs_n && !busy));

  assert_done_end_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (cs_n && !busy && !sclk));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_busy_start_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(start) && $fell(cs_n)));

  assert_rise_in_frame_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> !cs_n);
endmodule

bind spi_xfer_master spi_xfer_master_chk i_chk (.*);

// File: tb/test_spi_xfer_master.sv
module test_spi_xfer_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  len_code = '0;
  logic [7:0]  clk_div = '0;
  logic [7:0]  cs_delay = '0;
  logic [15:0] tx_word = '0;
  logic        miso = 1'b0;
  logic        cs_n, sclk, mosi, busy, done, cfg_err;
  logic [15:0] rx_word;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  int          sl_nb = 8;
  int          sl_idx = 0;
  logic [15:0] sl_word = '0;
  logic [15:0] mosi_cap = '0;

  always #10 clk = ~clk;

  spi_xfer_master i_spi_xfer_master (
    .clk(clk), .rst(rst), .start(start), .len_code(len_code),
    .clk_div(clk_div), .cs_delay(cs_delay), .tx_word(tx_word), .miso(miso),
    .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .busy(busy), .done(done),
    .cfg_err(cfg_err), .rx_word(rx_word)
  );

  // slave model: first bit at frame start, next bit after each falling edge
  always @(negedge cs_n) begin
    sl_idx = sl_nb - 1;
    miso = sl_word[sl_idx];
  end
  always @(negedge sclk) begin
    if (!cs_n && sl_idx > 0) begin
      sl_idx = sl_idx - 1;
      miso = sl_word[sl_idx];
    end
  end
  always @(posedge sclk) mosi_cap = {mosi_cap[14:0], mosi};

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic test_reset();
    check(cs_n == 1'b1, "R11", "cs_n after reset", cs_n, 1);
    check(sclk == 1'b0 && mosi == 1'b0, "R11", "sclk/mosi after reset", {sclk, mosi}, 0);
    check(busy == 1'b0 && done == 1'b0 && cfg_err == 1'b0, "R11", "flags after reset",
          {busy, done, cfg_err}, 0);
    check(rx_word == 16'h0, "R11", "rx_word after reset", rx_word, 0);
  endtask

  task automatic run_xfer(input int code, input int div, input int dly,
                          input logic [15:0] tx, input logic [15:0] sw);
    int nb;
    int hi;
    int lo;
    int lead;
    int cyc;
    int first;
    int last;
    int rises;
    int hi_w;
    int lo_w;
    int done_cyc;
    bit got;
    bit prev;
    logic [15:0] mask;
    logic [15:0] rxv;
    logic csv;
    string lreq;
    nb   = code + 8;
    hi   = (div / 2 < 1) ? 1 : div / 2;
    lo   = div - div / 2;
    lead = (dly != 0) ? dly : lo;
    mask = (nb == 16) ? 16'hFFFF : ((16'h1 << nb) - 16'h1);
    lreq = (dly == 0) ? "R6" : "R5";
    first = -1; last = 0; rises = 0; hi_w = 0; lo_w = 0; done_cyc = 0;
    got = 0; prev = 0; rxv = '0; csv = 1'b0;
    sl_nb = nb; sl_word = sw; mosi_cap = '0;
    @(negedge clk);
    len_code = 4'(code); clk_div = 8'(div); cs_delay = 8'(dly);
    tx_word = tx; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && !cs_n, "R10", "busy and cs_n low after start", {busy, cs_n}, 2);
    check(mosi == tx[nb-1], "R7", "first bit at cs_n fall", mosi, tx[nb-1]);
    cyc = 1;
    while (cyc < 20000) begin
      if (sclk && !prev) begin
        rises++;
        if (first < 0) first = cyc;
        last = cyc;
      end
      if (rises == 1 && sclk) hi_w++;
      if (rises == 1 && !sclk) lo_w++;
      if (done) begin
        got = 1; done_cyc = cyc; rxv = rx_word; csv = cs_n;
        break;
      end
      prev = sclk;
      @(negedge clk);
      cyc++;
    end
    check(got, "R9", "done seen", got, 1);
    check(first - 1 == lead, lreq, "lead cycles", first - 1, lead);
    check(hi_w == hi, "R4", "high phase", hi_w, hi);
    check(lo_w == lo, "R4", "low phase", lo_w, lo);
    check(rises == nb, "R1", "rising edges", rises, nb);
    check(done_cyc - last == hi, "R9", "tail after last rise", done_cyc - last, hi);
    check(csv == 1'b1, "R9", "cs_n high with done", csv, 1);
    check(rxv == (sw & mask), "R8", "rx_word", rxv, sw & mask);
    check((mosi_cap & mask) == (tx & mask), "R1", "mosi bits", mosi_cap & mask, tx & mask);
    @(negedge clk);
    check(!done && !busy, "R9", "done one cycle, busy low", {done, busy}, 0);
    check(rx_word == (sw & mask), "R9", "rx_word held", rx_word, sw & mask);
  endtask

  task automatic run_reject(input int code, input int div, input string req);
    @(negedge clk);
    len_code = 4'(code); clk_div = 8'(div); cs_delay = 8'd2;
    tx_word = 16'hFFFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(cfg_err == 1'b1, req, "cfg_err raised", cfg_err, 1);
    check(cs_n && !busy, req, "no transfer on refused start", {cs_n, busy}, 2);
    @(negedge clk);
    check(cfg_err == 1'b0, req, "cfg_err one cycle", cfg_err, 0);
    repeat (4) @(negedge clk);
    check(cs_n && !sclk && !busy, req, "bus still idle", {cs_n, sclk, busy}, 4);
  endtask

  task automatic run_busy_ignore();
    bit seen_low;
    sl_nb = 8; sl_word = 16'h0042; mosi_cap = '0;
    @(negedge clk);
    len_code = 4'd0; clk_div = 8'd2; cs_delay = 8'd1; tx_word = 16'h0081; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    len_code = 4'd8; clk_div = 8'd6; tx_word = 16'hFFFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    check(rx_word == 16'h0042, "R10", "rx_word unaffected by busy start", rx_word, 16'h42);
    check(mosi_cap[7:0] == 8'h81, "R10", "mosi unaffected by busy start", mosi_cap[7:0], 8'h81);
    seen_low = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!cs_n || busy) seen_low = 1;
    end
    check(!seen_low, "R10", "no second transfer", seen_low, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    run_xfer(0, 4, 3, 16'h00A5, 16'h003C);
    run_xfer(8, 5, 0, 16'hC3A1, 16'h5E0F);
    run_xfer(4, 1, 2, 16'hFB6D, 16'hF9A4);
    run_xfer(0, 255, 0, 16'h0153, 16'h00C6);
    run_xfer(1, 3, 7, 16'h0355, 16'h02AB);
    run_reject(9, 4, "R2");
    run_reject(15, 4, "R2");
    run_reject(0, 0, "R3");
    run_busy_ignore();
    finish_run();
  end
endmodule